// File: doc/BRIEF.md
# UART Interrupt Priority Resolver

This block collects the interrupt conditions of a serial port and reduces them to one active-high interrupt request and a four-bit source code that the host reads to find out what needs service. It keeps two pieces of state of its own: sticky receive error flags, and a pending flag for the transmitter-holding-empty event. Every other condition arrives as a level from the surrounding FIFO and modem logic.

A four-bit enable word masks each class of source. Masking hides a source from the interrupt line and from the source code. It does not change the state behind that source. The host clears an error condition by reading the status. It clears a transmitter-empty condition either by reading the source code while that code is shown, or by writing a new character.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset, `irq` is 0, `irq_src` is 4'b0001 and `err_flags` is 4'b0000.
- R2: Each enable bit gates one class of source. Bit 0 gates received data and character timeout. Bit 1 gates transmitter-holding-empty. Bit 2 gates receiver line status. Bit 3 gates modem status.
- R3: `err_flags` holds one sticky bit per error: bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break. A one-cycle pulse on an error input sets its bit at the next clock edge. `lsr_rd` clears all four bits. An error pulse in the same cycle as `lsr_rd` still leaves its own bit set.
- R4: `irq_src` reports the highest-priority enabled source. The sources and their codes, from highest to lowest priority, are: line status (any `err_flags` bit set) 4'b0110, received data 4'b0100 or character timeout 4'b1100, transmitter empty 4'b0010, modem status 4'b0000. When nothing is pending the code is 4'b0001.
- R5: Received data and character timeout share one priority level. When both are requested, the code is 4'b0100.
- R6: A low-to-high change of `thr_empty` sets the transmitter-empty pending flag. A `thr_empty` input that is held high from reset onward sets nothing.
- R7: Reading `irq_src` (`iid_rd`) clears the transmitter-empty pending flag only if that read returns 4'b0010. A read that returns any other code leaves the flag pending.
- R8: `thr_wr` clears the transmitter-empty pending flag.
- R9: `irq` is 1 exactly when `irq_src` differs from 4'b0001.
- R10: Masking a source does not clear its stored state. An error flag set while line status is masked is reported once its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier | input | 4 | Source enable word |
| overrun_err | input | 1 | Overrun error pulse |
| parity_err | input | 1 | Parity error pulse |
| framing_err | input | 1 | Framing error pulse |
| break_det | input | 1 | Break detected pulse |
| lsr_rd | input | 1 | Host reads line status; clears error flags |
| rx_data_req | input | 1 | Received data / trigger level reached |
| rx_timeout_req | input | 1 | Character timeout request |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Host writes the holding register |
| modem_chg | input | 1 | Modem status change pending |
| iid_rd | input | 1 | Host reads the source code |
| irq | output | 1 | Interrupt request |
| irq_src | output | 4 | Prioritized source code |
| err_flags | output | 4 | Sticky error flags |

## Verification
Two functions can act in the same cycle. A read of the source code can clear a pending transmitter-empty event in the cycle where a new break error arrives. A status read can also coincide with a fresh framing error. The bench provokes both in a single cycle. It then checks that the next code is line status with only the new flag bit set, and that the transmitter-empty event does not reappear once the errors are cleared.

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier,
  input  logic       overrun_err,
  input  logic       parity_err,
  input  logic       framing_err,
  input  logic       break_det,
  input  logic       lsr_rd,
  input  logic       rx_data_req,
  input  logic       rx_timeout_req,
  input  logic       thr_empty,
  input  logic       thr_wr,
  input  logic       modem_chg,
  input  logic       iid_rd,
  output logic       irq,
  output logic [3:0] irq_src,
  output logic [3:0] err_flags
);

  localparam logic [3:0] SRC_NONE  = 4'b0001;
  localparam logic [3:0] SRC_LINE  = 4'b0110;
  localparam logic [3:0] SRC_DATA  = 4'b0100;
  localparam logic [3:0] SRC_TOUT  = 4'b1100;
  localparam logic [3:0] SRC_THRE  = 4'b0010;
  localparam logic [3:0] SRC_MODEM = 4'b0000;

  logic [3:0] err_in;
  logic       thr_empty_q, thre_pend;
  logic       ls_act, rx_act, to_act, th_act, ms_act;
  logic       thre_rise, thre_clr;

  assign err_in = {break_det, framing_err, parity_err, overrun_err};

  always_ff @(posedge clk) begin
    if (!rst_n) err_flags <= '0;
    else        err_flags <= (lsr_rd ? 4'b0000 : err_flags) | err_in;
  end

  assign thre_rise = thr_empty & ~thr_empty_q;
  assign thre_clr  = thr_wr | (iid_rd & (irq_src == SRC_THRE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_empty_q <= 1'b1;
      thre_pend   <= 1'b0;
    end else begin
      thr_empty_q <= thr_empty;
      thre_pend   <= thre_rise | (thre_pend & ~thre_clr);
    end
  end

  assign ls_act = ier[2] & (|err_flags);
  assign rx_act = ier[0] & rx_data_req;
  assign to_act = ier[0] & rx_timeout_req;
  assign th_act = ier[1] & thre_pend;
  assign ms_act = ier[3] & modem_chg;

  always_comb begin
    if (ls_act)      irq_src = SRC_LINE;
    else if (rx_act) irq_src = SRC_DATA;
    else if (to_act) irq_src = SRC_TOUT;
    else if (th_act) irq_src = SRC_THRE;
    else if (ms_act) irq_src = SRC_MODEM;
    else             irq_src = SRC_NONE;
  end

  assign irq = ls_act | rx_act | to_act | th_act | ms_act;

endmodule

module uart_irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier,
  input logic       lsr_rd,
  input logic [3:0] err_in,
  input logic       rx_data_req,
  input logic       rx_timeout_req,
  input logic       thr_empty,
  input logic       thr_wr,
  input logic       iid_rd,
  input logic       irq,
  input logic [3:0] irq_src,
  input logic [3:0] err_flags
);

  a_r9_irq_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_src != 4'b0001));

  a_r3_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && err_in == 4'b0000) |=> err_flags == 4'b0000);

  a_r3_error_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in != 4'b0000) |=> (err_flags & $past(err_in)) == $past(err_in));

  a_r4_line_status_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && err_flags != 4'b0000) |-> irq_src == 4'b0110);

  a_r5_data_over_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[0] && rx_data_req && rx_timeout_req && err_flags == 4'b0000) |-> irq_src == 4'b0100);

  a_r8_write_clears_thre: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && $stable(thr_empty)) |=> irq_src != 4'b0010);

  a_r7_read_clears_thre: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && irq_src == 4'b0010 && $stable(thr_empty)) |=> irq_src != 4'b0010);

  a_r2_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'b0000) |-> (!irq && irq_src == 4'b0001));

endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ier(ier), .lsr_rd(lsr_rd),
  .err_in({break_det, framing_err, parity_err, overrun_err}),
  .rx_data_req(rx_data_req), .rx_timeout_req(rx_timeout_req),
  .thr_empty(thr_empty), .thr_wr(thr_wr), .iid_rd(iid_rd),
  .irq(irq), .irq_src(irq_src), .err_flags(err_flags)
);

// File: tb/uart_irq_arbiter_tb_top.sv
`timescale 1ns/100ps
module uart_irq_arbiter_tb_top;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ier = '0;
  logic overrun_err = 0, parity_err = 0, framing_err = 0, break_det = 0;
  logic lsr_rd = 0, rx_data_req = 0, rx_timeout_req = 0, thr_empty = 1;
  logic thr_wr = 0, modem_chg = 0, iid_rd = 0;
  logic irq;
  logic [3:0] irq_src, err_flags;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .ier(ier), .overrun_err(overrun_err),
    .parity_err(parity_err), .framing_err(framing_err), .break_det(break_det),
    .lsr_rd(lsr_rd), .rx_data_req(rx_data_req), .rx_timeout_req(rx_timeout_req),
    .thr_empty(thr_empty), .thr_wr(thr_wr), .modem_chg(modem_chg),
    .iid_rd(iid_rd), .irq(irq), .irq_src(irq_src), .err_flags(err_flags)
  );

  // {ier, rx_data_req, rx_timeout_req, modem_chg, expected code}
  localparam logic [10:0] VEC [8] = '{
    {4'b1111, 3'b111, 4'b0100},  // R5
    {4'b1111, 3'b011, 4'b1100},  // R4
    {4'b1111, 3'b001, 4'b0000},  // R4
    {4'b1110, 3'b111, 4'b0000},  // R2
    {4'b0111, 3'b001, 4'b0001},  // R2
    {4'b0001, 3'b010, 4'b1100},  // R2
    {4'b0000, 3'b111, 4'b0001},  // R2
    {4'b1001, 3'b101, 4'b0100}   // R4
  };

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    chk("R1 code", irq_src, 4'b0001);
    chk("R1 irq", {3'b0, irq}, 4'b0000);
    chk("R1 flags", err_flags, 4'b0000);
    rst_n = 1; step();

    for (int i = 0; i < 8; i++) begin
      {ier, rx_data_req, rx_timeout_req, modem_chg} = VEC[i][10:4];
      #1;
      chk("R4 table code", irq_src, VEC[i][3:0]);
      chk("R9 table irq", {3'b0, irq}, {3'b0, VEC[i][3:0] != 4'b0001});
    end

    ier = 4'b1111; rx_data_req = 1; rx_timeout_req = 0; modem_chg = 1;
    parity_err = 1; step(); parity_err = 0;
    chk("R3 parity flag", err_flags, 4'b0010);
    chk("R4 line status top", irq_src, 4'b0110);
    lsr_rd = 1; framing_err = 1; step(); lsr_rd = 0; framing_err = 0;
    chk("R3 set beats clear", err_flags, 4'b0100);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R3 cleared", err_flags, 4'b0000);
    chk("R4 back to data", irq_src, 4'b0100);

    ier = 4'b1011; overrun_err = 1; step(); overrun_err = 0;
    chk("R10 masked code", irq_src, 4'b0100);
    chk("R10 flag kept", err_flags, 4'b0001);
    ier = 4'b1111; #1;
    chk("R10 unmasked code", irq_src, 4'b0110);
    lsr_rd = 1; step(); lsr_rd = 0;

    rx_data_req = 0; #1;
    chk("R6 no event from reset", irq_src, 4'b0000);
    thr_wr = 1; thr_empty = 0; step(); thr_wr = 0;
    thr_empty = 1; step();
    chk("R6 rise sets", irq_src, 4'b0010);

    rx_data_req = 1; #1;
    iid_rd = 1; step(); iid_rd = 0;
    rx_data_req = 0; #1;
    chk("R7 other code keeps", irq_src, 4'b0010);
    iid_rd = 1; step(); iid_rd = 0;
    chk("R7 read clears", irq_src, 4'b0000);

    thr_empty = 0; step(); thr_empty = 1; step();
    chk("R6 second rise", irq_src, 4'b0010);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R8 write clears", irq_src, 4'b0000);

    thr_empty = 0; step(); thr_empty = 1; step();
    iid_rd = 1; break_det = 1; step(); iid_rd = 0; break_det = 0;
    chk("R4 break after read", irq_src, 4'b0110);
    chk("R3 break flag", err_flags, 4'b1000);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R7 cleared in same cycle", irq_src, 4'b0000);
    modem_chg = 0; #1;
    chk("R9 idle", {3'b0, irq}, 4'b0000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule